// File: doc/BRIEF.md
# Forward-Only Parallel Prefix Adder

This block adds two unsigned binary operands and a carry-in, producing a sum of the same width and a carry-out. Every carry comes from a parallel prefix network of identical generate/propagate combining cells.

The network runs strictly forward. At level k, each bit position at or above 2^k merges its running pair with the pair 2^k places below it. Positions below 2^k keep their pair unchanged. After ceil(log2(W)) levels, six for the default width of 64, each position holds the group generate of all bits at or below it. No reverse pass is needed to recover intermediate carries, and each cell output feeds at most two cells in the next level.

The carry-in is folded into bit 0 as an extra generate term. An optional single output register makes the adder usable inside a clocked pipeline. That register has a synchronous, active-high reset.

Top module: `ppadd_top`

## Requirements
- R1: With `sum` read as the low W bits and `cout` as bit W, the output pair equals the unsigned value `a + b + cin` for every operand pair.
- R2: The carry entering bit 0 equals `cin`. With both operands zero and `cin` = 1, `sum` is 1 and `cout` is 0. With `cin` = 0, both outputs are zero.
- R3: For every bit i ≥ 1, the carry into bit i, taken as `sum[i] ^ a[i] ^ b[i]`, equals `(a[i-1] & b[i-1]) | ((a[i-1] ^ b[i-1]) & carry into bit i-1)`.
- R4: `cout` equals `(a[W-1] & b[W-1]) | ((a[W-1] ^ b[W-1]) & carry into bit W-1)`. Consequently, all-ones plus 1 gives `sum` = 0 and `cout` = 1.
- R5: All-ones plus all-ones with `cin` = 1 gives `sum` = all ones and `cout` = 1.
- R6: Complementary alternating patterns (0xAA..AA plus 0x55..55) give all ones with `cout` = 0 when `cin` = 0. They give zero with `cout` = 1 when `cin` = 1.
- R7: With `REG_OUT` = 1, a result is presented on the clock edge after the inputs are applied. Until that edge, the outputs keep the previous result.
- R8: An edge that samples `rst` high leaves `sum` and `cout` at zero after it, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The assertions check three things on every clock. The carry chain recovered from the unregistered sum obeys the bitwise ripple recurrence, including the carry-in at bit 0 and the carry-out at the top. The registered result equals the arithmetic sum of the previous cycle's inputs. A reset edge clears the outputs. Only the directed scenarios show that specific long-carry patterns resolve as intended: all-ones plus one, all-ones plus all-ones, and complementary alternating patterns. Only they show that the outputs hold their old value between input change and clock edge.

// File: rtl/ppadd_pkg.sv
package ppadd_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge a higher-order group (hi) with the adjacent lower-order group (lo).
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    function automatic int unsigned level_count(input int unsigned w);
        return (w <= 1) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/ppadd_bitgen.sv
module ppadd_bitgen
    import ppadd_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output gp_t  [WIDTH-1:0] pairs,
    output logic [WIDTH-1:0] half_sum
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign half_sum[i] = a[i] ^ b[i];
            if (i == 0) begin : g_fold
                // Carry-in acts as a generate term just below bit 0.
                assign pairs[i].g = (a[i] & b[i]) | (half_sum[i] & cin);
            end else begin : g_plain
                assign pairs[i].g = a[i] & b[i];
            end
            assign pairs[i].p = half_sum[i];
        end
    endgenerate
endmodule

// File: rtl/ppadd_level.sv
module ppadd_level
    import ppadd_pkg::*;
#(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned SPAN  = 1
) (
    input  gp_t [WIDTH-1:0] din,
    output gp_t [WIDTH-1:0] dout
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pos
            if (i >= SPAN) begin : g_cell
                assign dout[i] = gp_merge(din[i], din[i-SPAN]);
            end else begin : g_pass
                assign dout[i] = din[i];
            end
        end
    endgenerate
endmodule

// File: rtl/ppadd_sum.sv
module ppadd_sum
    import ppadd_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] half_sum,
    input  gp_t  [WIDTH-1:0] groups,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] carry;

    always_comb begin
        carry[0] = cin;
        for (int i = 1; i < WIDTH; i++) begin
            carry[i] = groups[i-1].g;
        end
    end

    assign sum  = half_sum ^ carry;
    assign cout = groups[WIDTH-1].g;
endmodule

// File: rtl/ppadd_top.sv
module ppadd_top
    import ppadd_pkg::*;
#(
    parameter int unsigned WIDTH   = 64,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned LEVELS = level_count(WIDTH);

    gp_t  [LEVELS:0][WIDTH-1:0] tree;
    logic [WIDTH-1:0]           half_sum;
    logic [WIDTH-1:0]           sum_c;
    logic                       cout_c;

    ppadd_bitgen #(.WIDTH(WIDTH)) u_bitgen (
        .a        (a),
        .b        (b),
        .cin      (cin),
        .pairs    (tree[0]),
        .half_sum (half_sum)
    );

    genvar k;
    generate
        for (k = 0; k < LEVELS; k++) begin : g_level
            ppadd_level #(.WIDTH(WIDTH), .SPAN(1 << k)) u_level (
                .din  (tree[k]),
                .dout (tree[k+1])
            );
        end
    endgenerate

    ppadd_sum #(.WIDTH(WIDTH)) u_sum (
        .half_sum (half_sum),
        .groups   (tree[LEVELS]),
        .cin      (cin),
        .sum      (sum_c),
        .cout     (cout_c)
    );

    // Carries recovered from the prefix result, checked against a ripple recurrence.
    logic [WIDTH-1:0] carry_seen;
    logic [WIDTH-1:0] gen_bit;
    assign carry_seen = sum_c ^ a ^ b;
    assign gen_bit    = a & b;

    AST_CIN_AT_BIT0: assert property (@(posedge clk) disable iff (rst)
        carry_seen[0] == cin); // R2

    AST_RIPPLE_CHAIN: assert property (@(posedge clk) disable iff (rst)
        carry_seen[WIDTH-1:1] ==
        (gen_bit[WIDTH-2:0] | (half_sum[WIDTH-2:0] & carry_seen[WIDTH-2:0]))); // R3

    AST_COUT_CHAIN: assert property (@(posedge clk) disable iff (rst)
        cout_c == (gen_bit[WIDTH-1] | (half_sum[WIDTH-1] & carry_seen[WIDTH-1]))); // R4

    generate
        if (REG_OUT) begin : g_reg
            logic past_ok;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sum     <= '0;
                    cout    <= 1'b0;
                    past_ok <= 1'b0;
                end else begin
                    sum     <= sum_c;
                    cout    <= cout_c;
                    past_ok <= 1'b1;
                end
            end

            AST_RESET_CLEARS: assert property (@(posedge clk)
                rst |=> (sum == '0 && cout == 1'b0)); // R8

            AST_REG_ARITH: assert property (@(posedge clk) disable iff (rst)
                past_ok |-> ({cout, sum} ==
                    $past({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))); // R1 R7
        end else begin : g_comb
            assign sum  = sum_c;
            assign cout = cout_c;
        end
    endgenerate
endmodule

// File: tb/tb_ppadd_top.sv
module tb_ppadd_top;
    localparam int unsigned W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    ppadd_top #(.WIDTH(W), .REG_OUT(1'b1)) dut (
        .clk (clk), .rst (rst), .a (a), .b (b), .cin (cin),
        .sum (sum), .cout (cout)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at a falling edge, confirm the old value holds, then read after the next rising edge.
    task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] xb,
                         input logic xc, input string req);
        logic [W:0] prev;
        logic [W:0] exp;
        @(negedge clk);
        prev = {cout, sum};
        a = xa; b = xb; cin = xc;
        #1;
        check("R7 hold", {cout, sum}, prev);
        exp = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc};
        @(negedge clk);
        check(req, {cout, sum}, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; a = '1; b = '1; cin = 1'b1;
        @(negedge clk);
        check("R8 reset clears", {cout, sum}, '0);
        rst = 1'b0;
    endtask

    task automatic t_zero;
        apply('0, '0, 1'b0, "R2 zero operands");
        apply('0, '0, 1'b1, "R2 carry-in only");
    endtask

    task automatic t_ones_plus_one;
        apply('1, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R4 all-ones plus one");
        apply('1, '0, 1'b1, "R4 all-ones plus carry-in");
    endtask

    task automatic t_ones_both;
        apply('1, '1, 1'b1, "R5 all-ones twice with carry-in");
        apply('1, '1, 1'b0, "R5 all-ones twice");
    endtask

    task automatic t_alternating;
        apply({(W/2){2'b10}}, {(W/2){2'b01}}, 1'b0, "R6 alternating no cin");
        apply({(W/2){2'b10}}, {(W/2){2'b01}}, 1'b1, "R6 alternating with cin");
        apply({(W/2){2'b10}}, {(W/2){2'b10}}, 1'b0, "R3 alternating doubled");
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
        end
    endtask

    task automatic t_carry_walk;
        // A single generate at bit j running through a propagate chain above it.
        for (int j = 0; j < W; j += 7) begin
            apply('1 << j, {{(W-1){1'b0}}, 1'b1} << j, 1'b0, "R3 carry walk");
        end
    endtask

    task automatic t_reset_midstream;
        @(negedge clk);
        a = '1; b = '1; cin = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R8 reset while busy", {cout, sum}, '0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset;
        t_zero;
        t_ones_plus_one;
        t_ones_both;
        t_alternating;
        t_carry_walk;
        t_random;
        t_reset_midstream;
        t_zero;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule